// File: doc/BRIEF.md
# I2C High-Speed Mode Switch

This block sits beside the byte engine of an I2C slave that fronts a sampling converter, and it tracks the bus speed mode. It watches SCL and SDA, which the block samples on its own clock. In standard or fast mode, a first byte after START whose upper five bits are `00001` is a high-speed master code. That byte is left unacknowledged, and the block raises its high-speed flag at the end of the byte's ninth clock. The flag survives repeated STARTs and drops only on STOP or reset.

While in high-speed mode, a valid command written to this slave starts a conversion that cannot finish within one bus bit. On the SCL falling edge after the command's acknowledge clock, the block raises an SCL pull-down enable. It holds SCL low until the converter reports completion. Reads are also limited by mode. In high-speed mode each read address allows one two-byte word. In standard or fast mode it allows up to four words. A permission output marks the data bytes that may carry defined data.

Top module: `i2c_hs_switch`

## Requirements
- R1: After reset, `hs_mode_o`, `scl_hold_o` and `rd_ok_o` are all 0.
- R2: In standard or fast mode, the first byte after a START is checked on its acknowledge clock (the ninth SCL rise). If bits 7:3 of that byte are `00001`, whatever bits 2:0 hold, `hs_mode_o` becomes 1. Any other first byte leaves `hs_mode_o` at 0.
- R3: A repeated START while in high-speed mode leaves `hs_mode_o` at 1.
- R4: A STOP (SDA rising while SCL is high) clears `hs_mode_o` and `scl_hold_o`.
- R5: Suppose high-speed mode is active and the first byte after a START is the write address {`DEV_ID`, `dev_sel_i`, 0}. If the second byte has bits 7:5 equal to 000, `scl_hold_o` rises after the SCL fall that follows that byte's acknowledge clock.
- R6: `scl_hold_o` falls on the first clock edge that samples `conv_done_i` high, and it stays 1 until then.
- R7: A command byte with any of bits 7:5 set never raises `scl_hold_o`.
- R8: `scl_hold_o` is never 1 outside high-speed mode, so a valid command in standard or fast mode does not stretch SCL.
- R9: After a matching read address {`DEV_ID`, `dev_sel_i`, 1} in high-speed mode, `rd_ok_o` is 1 until two data-byte acknowledge clocks have passed, and 0 after that.
- R10: After a matching read address in standard or fast mode, `rd_ok_o` stays 1 through the first seven data-byte acknowledge clocks and falls on the eighth.
- R11: A read address whose select bits differ from `dev_sel_i` leaves `rd_ok_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_sel_i | input | SEL_W | Low address bits strapped for this slave |
| conv_done_i | input | 1 | Conversion complete from the converter core |
| hs_mode_o | output | 1 | High-speed mode active |
| scl_hold_o | output | 1 | Enable for the SCL pull-down |
| rd_ok_o | output | 1 | The current read data byte is within the word limit |

## Verification
The assertions assume that SCL and SDA each stay steady for several system clocks between edges. This lets the synchroniser turn every bus transition into exactly one event. They also assume that `conv_done_i` is raised only while a stretch is pending or active. The stimulus keeps four clocks per bus phase and changes SDA only while SCL is low, except when it forms a START or STOP on purpose. It feeds `scl_hold_o` back into the SCL the block sees, as a wired-AND. It pulses `conv_done_i` only during a stretch.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

  localparam logic [4:0] MC_PREFIX   = 5'b00001;
  localparam int         BYTE_W      = 8;
  localparam int         IDX_W       = 2;
  localparam int         CMD_ZERO_W  = 3;

endpackage

// File: rtl/hs_bus_cond.sv
module hs_bus_cond
  import i2c_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o,
  output logic     sda_o
);

  logic scl_s, sda_s;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_s <= 1'b1;
          sda_s <= 1'b1;
        end else begin
          scl_s <= scl_i;
          sda_s <= sda_i;
        end
      end
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync <= '1;
          sda_sync <= '1;
        end else begin
          scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
          sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_sync[SYNC_STAGES-1];
      assign sda_s = sda_sync[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    evt_o.start = scl_s & scl_p & sda_p & ~sda_s;
    evt_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
    evt_o.rise  = scl_s & ~scl_p;
    evt_o.fall  = ~scl_s & scl_p;
  end

  assign sda_o = sda_s;

endmodule

// File: rtl/hs_byte_frame.sv
module hs_byte_frame
  import i2c_hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic              sda_i,
  output logic              byte_done_o,
  output logic              ack_done_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [IDX_W-1:0]  byte_idx_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [IDX_W-1:0]  idx_q;

  assign byte_done_o = evt_i.rise & (bit_cnt == LAST_BIT);
  assign ack_done_o  = evt_i.rise & (bit_cnt == ACK_BIT);
  assign data_o      = {shreg, sda_i};
  assign byte_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      shreg   <= '0;
      idx_q   <= '0;
    end else if (evt_i.start || evt_i.stop) begin
      bit_cnt <= '0;
      idx_q   <= '0;
    end else if (evt_i.rise) begin
      if (bit_cnt == ACK_BIT) begin
        bit_cnt <= '0;
        if (idx_q != '1) idx_q <= idx_q + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {shreg[BYTE_W-3:0], sda_i};
      end
    end
  end

endmodule

// File: rtl/hs_mode_ctrl.sv
module hs_mode_ctrl
  import i2c_hs_pkg::*;
#(
  parameter int SEL_W          = 2,
  parameter int DEV_ID_W       = 5,
  parameter logic [DEV_ID_W-1:0] DEV_ID = 5'b10010,
  parameter int FS_WORDS       = 4,
  parameter int HS_WORDS       = 1,
  parameter int BYTES_PER_WORD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic              byte_done_i,
  input  logic              ack_done_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [IDX_W-1:0]  byte_idx_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              conv_done_i,
  output logic              hs_mode_o,
  output logic              scl_hold_o,
  output logic              rd_ok_o
);

  localparam int FS_BYTES = FS_WORDS * BYTES_PER_WORD;
  localparam int HS_BYTES = HS_WORDS * BYTES_PER_WORD;
  localparam int DCNT_W   = $clog2(FS_BYTES + 1);
  localparam logic [DCNT_W-1:0] FS_LIM = DCNT_W'(FS_BYTES);
  localparam logic [DCNT_W-1:0] HS_LIM = DCNT_W'(HS_BYTES);

  logic hs_q, hold_q, arm_q;
  logic mc_pend, addr_hit, addr_rd;
  logic wr_addr_q, cmd_pend, rd_act;
  logic [DCNT_W-1:0] dcnt;

  logic first_byte, second_byte;
  assign first_byte  = (byte_idx_i == IDX_W'(0));
  assign second_byte = (byte_idx_i == IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q      <= 1'b0;
      hold_q    <= 1'b0;
      arm_q     <= 1'b0;
      mc_pend   <= 1'b0;
      addr_hit  <= 1'b0;
      addr_rd   <= 1'b0;
      wr_addr_q <= 1'b0;
      cmd_pend  <= 1'b0;
      rd_act    <= 1'b0;
      dcnt      <= '0;
    end else if (evt_i.start || evt_i.stop) begin
      if (evt_i.stop) begin
        hs_q   <= 1'b0;
        hold_q <= 1'b0;
      end
      arm_q     <= 1'b0;
      mc_pend   <= 1'b0;
      addr_hit  <= 1'b0;
      wr_addr_q <= 1'b0;
      cmd_pend  <= 1'b0;
      rd_act    <= 1'b0;
      dcnt      <= '0;
    end else begin
      if (byte_done_i && first_byte) begin
        mc_pend  <= ~hs_q && (data_i[BYTE_W-1 -: 5] == MC_PREFIX);
        addr_hit <= (data_i[BYTE_W-1:1] == {DEV_ID, dev_sel_i});
        addr_rd  <= data_i[0];
      end
      if (byte_done_i && second_byte && wr_addr_q)
        cmd_pend <= (data_i[BYTE_W-1 -: CMD_ZERO_W] == '0);
      if (ack_done_i && first_byte) begin
        if (mc_pend) hs_q <= 1'b1;
        wr_addr_q <= addr_hit & ~addr_rd;
        rd_act    <= addr_hit & addr_rd;
      end
      if (ack_done_i && second_byte && cmd_pend && hs_q)
        arm_q <= 1'b1;
      if (ack_done_i && !first_byte && rd_act && dcnt != FS_LIM)
        dcnt <= dcnt + 1'b1;
      // pull SCL only once it is already low
      if (evt_i.fall && arm_q) begin
        hold_q <= 1'b1;
        arm_q  <= 1'b0;
      end else if (hold_q && conv_done_i) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign hs_mode_o  = hs_q;
  assign scl_hold_o = hold_q;
  assign rd_ok_o    = rd_act && (dcnt < (hs_q ? HS_LIM : FS_LIM));

endmodule

// File: rtl/i2c_hs_switch.sv
module i2c_hs_switch
  import i2c_hs_pkg::*;
#(
  parameter int SEL_W          = 2,
  parameter int DEV_ID_W       = 5,
  parameter logic [DEV_ID_W-1:0] DEV_ID = 5'b10010,
  parameter int FS_WORDS       = 4,
  parameter int HS_WORDS       = 1,
  parameter int BYTES_PER_WORD = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  input  logic             conv_done_i,
  output logic             hs_mode_o,
  output logic             scl_hold_o,
  output logic             rd_ok_o
);

  bus_evt_t          evt;
  logic              sda_s;
  logic              byte_done, ack_done;
  logic [BYTE_W-1:0] data;
  logic [IDX_W-1:0]  byte_idx;
  logic              stop_evt;

  assign stop_evt = evt.stop;

  hs_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .evt_o  (evt),
    .sda_o  (sda_s)
  );

  hs_byte_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .sda_i       (sda_s),
    .byte_done_o (byte_done),
    .ack_done_o  (ack_done),
    .data_o      (data),
    .byte_idx_o  (byte_idx)
  );

  hs_mode_ctrl #(
    .SEL_W          (SEL_W),
    .DEV_ID_W       (DEV_ID_W),
    .DEV_ID         (DEV_ID),
    .FS_WORDS       (FS_WORDS),
    .HS_WORDS       (HS_WORDS),
    .BYTES_PER_WORD (BYTES_PER_WORD)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .byte_done_i (byte_done),
    .ack_done_i  (ack_done),
    .data_i      (data),
    .byte_idx_i  (byte_idx),
    .dev_sel_i   (dev_sel_i),
    .conv_done_i (conv_done_i),
    .hs_mode_o   (hs_mode_o),
    .scl_hold_o  (scl_hold_o),
    .rd_ok_o     (rd_ok_o)
  );

endmodule

// File: rtl/i2c_hs_switch_chk.sv
module i2c_hs_switch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_mode_o,
  input logic scl_hold_o,
  input logic conv_done_i,
  input logic stop_evt
);

  // R8
  hold_in_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o |-> hs_mode_o);

  // R4
  hs_exit_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_mode_o) |-> $past(stop_evt));

  // R6
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && conv_done_i) |=> !scl_hold_o);

  // R6
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_o && !conv_done_i && !stop_evt) |=> scl_hold_o);

  // R5
  hold_start_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_hold_o) |-> $past(hs_mode_o));

endmodule

bind i2c_hs_switch i2c_hs_switch_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hs_mode_o   (hs_mode_o),
  .scl_hold_o  (scl_hold_o),
  .conv_done_i (conv_done_i),
  .stop_evt    (stop_evt)
);

// File: tb/i2c_hs_switch_tb_top.sv
module i2c_hs_switch_tb_top;

  localparam logic [4:0] ID  = 5'b10010;
  localparam logic [1:0] SEL = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic conv_done = 1'b0;
  logic hs, hold, rd_ok;
  logic scl_bus;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  assign scl_bus = scl_m & ~hold;

  i2c_hs_switch dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_bus),
    .sda_i       (sda_m),
    .dev_sel_i   (SEL),
    .conv_done_i (conv_done),
    .hs_mode_o   (hs),
    .scl_hold_o  (hold),
    .rd_ok_o     (rd_ok)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b);
    scl_m = 1'b0; sda_m = b; wt(4);
    scl_m = 1'b1; wt(4);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
  endtask

  task automatic bus_start;
    scl_m = 1'b0; sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(4);
    sda_m = 1'b0; wt(4);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; sda_m = 1'b0; wt(4);
    scl_m = 1'b1; wt(4);
    sda_m = 1'b1; wt(4);
  endtask

  task automatic enter_hs;
    bus_start();
    bus_byte(8'h0D);
    bus_bit(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wt(3);
    chk("R1 hs", hs, 1'b0);
    chk("R1 hold", hold, 1'b0);
    chk("R1 rd_ok", rd_ok, 1'b0);
    rst_n = 1'b1;
    wt(4);

    // R2, R4: sweep first bytes 0x00..0x0F
    for (int b = 0; b < 16; b++) begin
      bus_start();
      bus_byte(8'(b));
      bus_bit(1'b1);
      chk("R2 master code", hs, (b >= 8));
      bus_stop();
      wt(2);
      chk("R4 stop exit", hs, 1'b0);
    end

    // R3
    enter_hs();
    bus_start();
    chk("R3 repeated start", hs, 1'b1);
    bus_stop();
    wt(2);

    // R5, R6, R7: command upper bits sweep in HS
    for (int c = 0; c < 8; c++) begin
      enter_hs();
      bus_start();
      bus_byte({ID, SEL, 1'b0});
      bus_bit(1'b0);
      bus_byte({3'(c), 5'b10101});
      bus_bit(1'b0);
      wt(1);
      if (c == 0) begin
        chk("R5 hold after cmd", hold, 1'b1);
        wt(5);
        chk("R6 hold kept", hold, 1'b1);
        conv_done = 1'b1;
        chk("R6 hold before edge", hold, 1'b1);
        wt(1);
        conv_done = 1'b0;
        chk("R6 hold released", hold, 1'b0);
      end else begin
        chk("R7 bad cmd no hold", hold, 1'b0);
      end
      bus_stop();
      wt(2);
      chk("R4 stop exit", hs, 1'b0);
    end

    // R8: valid command in F/S
    bus_start();
    bus_byte({ID, SEL, 1'b0});
    bus_bit(1'b0);
    bus_byte(8'h1F);
    bus_bit(1'b0);
    wt(6);
    chk("R8 no hold in F/S", hold, 1'b0);
    bus_stop();

    // R9: HS read one word
    enter_hs();
    bus_start();
    bus_byte({ID, SEL, 1'b1});
    bus_bit(1'b0);
    chk("R9 rd_ok word start", rd_ok, 1'b1);
    bus_byte(8'hFF); bus_bit(1'b0);
    chk("R9 rd_ok second byte", rd_ok, 1'b1);
    bus_byte(8'hFF); bus_bit(1'b1);
    chk("R9 rd_ok after word", rd_ok, 1'b0);
    bus_stop();

    // R10: F/S read four words
    bus_start();
    bus_byte({ID, SEL, 1'b1});
    bus_bit(1'b0);
    for (int k = 1; k <= 8; k++) begin
      bus_byte(8'hFF);
      bus_bit(k == 8);
      chk("R10 fs read window", rd_ok, (k < 8));
    end
    bus_stop();

    // R11: wrong select
    bus_start();
    bus_byte({ID, 2'b01, 1'b1});
    bus_bit(1'b1);
    chk("R11 mismatch", rd_ok, 1'b0);
    bus_stop();
    wt(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule